// File: doc/BRIEF.md
# Serial LED Driver Control Front End

This block is the digital control logic of a 48-channel LED driver. A 49-bit shift register collects serial data one bit per rising edge of a shift clock. Its top bit is the serial output, so several devices can share one data line in a chain. A rising edge on a separate latch input sends the register contents to one of two places. The top bit picks the place: the per-channel enable latch, or a control latch. The control latch holds the brightness, maximum-current and function settings. When the enable latch is loaded, the shift register is refilled on that same action with a chosen status word, which the host can then shift out. A blanking input turns every channel off.

All four serial-side pins are sampled into the system clock domain by a synchronizer. Rising edges are found from the synchronized levels. A three-state controller then runs exactly one action per detected edge:

- `ST_IDLE` holds the register.
- `ST_SHIFT` moves it one place.
- `ST_LATCH` routes its contents.

Transitions:

- Any state goes to `ST_LATCH` on a latch edge. This edge wins when a shift edge arrives in the same cycle.
- Any state goes to `ST_SHIFT` on a shift edge that has no latch edge with it.
- Any state goes back to `ST_IDLE` otherwise.

The analog current sinks and fault detection are outside the block. Status words arrive as plain inputs.

Top module: `led_serial_front`

## Requirements
- R1: After reset, every latch (enable and control) and the shift register are zero, so `out_en`, `ser_out`, `bright`, `maxcur` and `func_ctl` read 0.
- R2: Each rising edge of `shift_clk` moves the register one place toward bit 48, with `ser_in` entering at bit 0. Holding `ser_in` high across two edges sets exactly bits 0 and 1. `ser_out` always shows bit 48.
- R3: On a rising edge of `latch_in` with bit 48 equal to 0, the enable latch takes bits 47:0, and `out_en[k]` belongs to channel k: red 0–15, green 16–31, blue 32–47.
- R4: The same enable-latch action reloads the register with bit 48 = 0 and bits 47:0 = `stat_words[n*48 +: 48]`, where n is the 2-bit status select held in `func_ctl[1:0]`.
- R5: On a rising edge of `latch_in` with bit 48 equal to 1, the control latch takes bits 47:0. The bit layout is:
  - `bright` = bits 20:0 (7 bits per colour, red lowest).
  - `maxcur` = bits 29:21 (3 bits per colour, red lowest).
  - `func_ctl` = bits 47:30.
  The enable latch keeps its value.
- R6: In a two-device chain sharing the clock, shift and latch pins, 98 shifts place the first 49 bits sent in the far device and the last 49 in the near device.
- R7: While `blank_in` is high, `out_en` is all zero. When it is low, `out_en` equals the enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial data in |
| shift_clk | input | 1 | Serial shift clock (sampled) |
| latch_in | input | 1 | Latch strobe (sampled) |
| blank_in | input | 1 | Force all channels off |
| stat_words | input | 192 | Four 48-bit status words, word n at bits n*48 upward |
| ser_out | output | 1 | Shift register bit 48 |
| out_en | output | 48 | Channel enables |
| bright | output | 21 | Brightness, 7 bits per colour |
| maxcur | output | 9 | Maximum current, 3 bits per colour |
| func_ctl | output | 18 | Function field, bits 1:0 select the status word |

## Verification
A pin rise is acted on at the fourth rising clock edge after it: two synchronizer stages, the edge-history register, then the action state. `out_en` follows one edge later. A change on `blank_in` reaches `out_en` at the third edge.

The bench changes pins on falling edges and holds each shift or latch level for four cycles. Every check comes at least four cycles after the last action is due. Data is set two cycles before each shift edge, so the synchronized data is steady when it is captured.

// File: rtl/led_fe_pkg.sv
package led_fe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } fe_state_t;
endpackage

// File: rtl/led_fe_sync.sv
module led_fe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/led_fe_ctrl.sv
module led_fe_ctrl
    import led_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ser_s,
    input  logic      shift_s,
    input  logic      latch_s,
    output fe_state_t state,
    output logic      shift_bit
);
    logic      shift_q, latch_q;
    logic      shift_rise, latch_rise;
    fe_state_t nxt;

    assign shift_rise = shift_s & ~shift_q;
    assign latch_rise = latch_s & ~latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            shift_q <= shift_s;
            latch_q <= latch_s;
        end
    end

    always_comb begin
        unique case ({latch_rise, shift_rise})
            2'b10, 2'b11: nxt = ST_LATCH;
            2'b01:        nxt = ST_SHIFT;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // data capture alongside the shift decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                shift_bit <= 1'b0;
        else if (nxt == ST_SHIFT)  shift_bit <= ser_s;
    end

    a_r2_one_shift_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SHIFT |=> state != ST_SHIFT);
    a_r3_latch_edge_acts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_s) |=> state == ST_LATCH);
endmodule

// File: rtl/led_fe_regs.sv
module led_fe_regs
    import led_fe_pkg::*;
#(
    parameter int N_PER_COLOR = 16,
    parameter int BC_W        = 7,
    parameter int MC_W        = 3,
    parameter int SEL_W       = 2,
    localparam int N_OUT      = 3 * N_PER_COLOR,
    localparam int SR_W       = N_OUT + 1,
    localparam int N_STAT     = 2 ** SEL_W,
    localparam int MC_LSB     = 3 * BC_W,
    localparam int FC_LSB     = 3 * BC_W + 3 * MC_W,
    localparam int FC_W       = N_OUT - FC_LSB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fe_state_t                state,
    input  logic                     shift_bit,
    input  logic                     blank_s,
    input  logic [N_STAT*N_OUT-1:0]  stat_words,
    output logic                     ser_out,
    output logic [N_OUT-1:0]         out_en,
    output logic [3*BC_W-1:0]        bright,
    output logic [3*MC_W-1:0]        maxcur,
    output logic [FC_W-1:0]          func_ctl
);
    logic [SR_W-1:0]  sr;
    logic [N_OUT-1:0] onoff;
    logic [N_OUT-1:0] ctl;
    logic [SEL_W-1:0] sel;
    logic [N_OUT-1:0] stat_pick;

    assign sel       = ctl[FC_LSB +: SEL_W];
    assign stat_pick = stat_words[int'(sel)*N_OUT +: N_OUT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            onoff <= '0;
            ctl   <= '0;
        end else begin
            unique case (state)
                ST_SHIFT: sr <= {sr[SR_W-2:0], shift_bit};
                ST_LATCH: begin
                    if (!sr[SR_W-1]) begin
                        onoff <= sr[N_OUT-1:0];
                        sr    <= {1'b0, stat_pick};
                    end else begin
                        ctl   <= sr[N_OUT-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       out_en <= '0;
        else if (blank_s) out_en <= '0;
        else              out_en <= onoff;
    end

    assign ser_out  = sr[SR_W-1];
    assign bright   = ctl[MC_LSB-1:0];
    assign maxcur   = ctl[FC_LSB-1:MC_LSB];
    assign func_ctl = ctl[N_OUT-1:FC_LSB];

    a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SHIFT |=> sr[SR_W-1:1] == $past(sr[SR_W-2:0]));
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |=> $stable(sr));
    a_r3_onoff_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !sr[SR_W-1]) |=> onoff == $past(sr[N_OUT-1:0]));
    a_r4_reload_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !sr[SR_W-1]) |=> !sr[SR_W-1]);
    a_r5_ctl_keeps_onoff: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && sr[SR_W-1]) |=> $stable(onoff));
    a_r7_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
        blank_s |=> out_en == '0);
endmodule

// File: rtl/led_serial_front.sv
module led_serial_front
    import led_fe_pkg::*;
#(
    parameter int N_PER_COLOR = 16,
    parameter int BC_W        = 7,
    parameter int MC_W        = 3,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int N_OUT      = 3 * N_PER_COLOR,
    localparam int N_STAT     = 2 ** SEL_W,
    localparam int FC_W       = N_OUT - 3 * BC_W - 3 * MC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_in,
    input  logic                    shift_clk,
    input  logic                    latch_in,
    input  logic                    blank_in,
    input  logic [N_STAT*N_OUT-1:0] stat_words,
    output logic                    ser_out,
    output logic [N_OUT-1:0]        out_en,
    output logic [3*BC_W-1:0]       bright,
    output logic [3*MC_W-1:0]       maxcur,
    output logic [FC_W-1:0]         func_ctl
);
    logic [3:0] pins_s;
    fe_state_t  state;
    logic       shift_bit;

    led_fe_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({blank_in, latch_in, shift_clk, ser_in}),
        .q     (pins_s)
    );

    led_fe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_s     (pins_s[0]),
        .shift_s   (pins_s[1]),
        .latch_s   (pins_s[2]),
        .state     (state),
        .shift_bit (shift_bit)
    );

    led_fe_regs #(
        .N_PER_COLOR (N_PER_COLOR),
        .BC_W        (BC_W),
        .MC_W        (MC_W),
        .SEL_W       (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .shift_bit  (shift_bit),
        .blank_s    (pins_s[3]),
        .stat_words (stat_words),
        .ser_out    (ser_out),
        .out_en     (out_en),
        .bright     (bright),
        .maxcur     (maxcur),
        .func_ctl   (func_ctl)
    );
endmodule

// File: tb/led_serial_front_test.sv
module led_serial_front_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, shift_clk = 1'b0, latch_in = 1'b0, blank_in = 1'b0;
    logic chain_mid;
    logic ser_out_b;
    logic [47:0] en_a, en_b;
    logic [20:0] br_a, br_b;
    logic [8:0]  mc_a, mc_b;
    logic [17:0] fc_a, fc_b;
    int total = 0;
    int bad = 0;

    localparam logic [191:0] SW_A = {48'hA3A3_0000_0003, 48'hA2A2_1234_5678,
                                     48'hA1A1_0F0F_0F0F, 48'hA0A0_DEAD_BEEF};
    localparam logic [191:0] SW_B = {48'hB3B3_FFFF_0000, 48'hB2B2_0000_FFFF,
                                     48'hB1B1_CAFE_F00D, 48'hB0B0_5555_AAAA};

    // {far device pattern, near device pattern}
    localparam logic [95:0] VEC [4] = '{
        {48'h0000_0000_0001, 48'h8000_0000_0000},
        {48'hFFFF_0000_FFFF, 48'h0000_FFFF_0000},
        {48'h1234_5678_9ABC, 48'hFEDC_BA98_7654},
        {48'hAAAA_5555_C3C3, 48'h5A5A_A5A5_0FF0}
    };

    always #2 clk = ~clk;

    led_serial_front uut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .latch_in(latch_in), .blank_in(blank_in), .stat_words(SW_A),
        .ser_out(chain_mid), .out_en(en_a), .bright(br_a), .maxcur(mc_a),
        .func_ctl(fc_a)
    );

    led_serial_front uut_b (
        .clk(clk), .rst_n(rst_n), .ser_in(chain_mid), .shift_clk(shift_clk),
        .latch_in(latch_in), .blank_in(blank_in), .stat_words(SW_B),
        .ser_out(ser_out_b), .out_en(en_b), .bright(br_b), .maxcur(mc_b),
        .func_ctl(fc_b)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_one(input logic b);
        ser_in = b;
        waitn(2);
        shift_clk = 1'b1;
        waitn(4);
        shift_clk = 1'b0;
        waitn(4);
    endtask

    task automatic latch_pulse();
        latch_in = 1'b1;
        waitn(4);
        latch_in = 1'b0;
        waitn(4);
    endtask

    task automatic send_chain(input logic [48:0] far, input logic [48:0] near);
        for (int i = 48; i >= 0; i--) shift_one(far[i]);
        for (int i = 48; i >= 0; i--) shift_one(near[i]);
    endtask

    task automatic read_chain(output logic [97:0] got);
        for (int i = 0; i < 98; i++) begin
            got[97-i] = ser_out_b;
            shift_one(1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [97:0] got;
        logic [47:0] last_a, last_b;
        waitn(5);
        rst_n = 1'b1;
        waitn(2);
        // R1 reset state
        chk("R1 out_en a", 64'(en_a), 64'd0);
        chk("R1 out_en b", 64'(en_b), 64'd0);
        chk("R1 ser_out", 64'(ser_out_b), 64'd0);
        chk("R1 bright", 64'(br_a), 64'd0);
        chk("R1 maxcur", 64'(mc_a), 64'd0);
        chk("R1 func", 64'(fc_a), 64'd0);

        // R2 two edges with data high set two low bits only
        shift_one(1'b1);
        shift_one(1'b1);
        latch_pulse();
        chk("R2 two ones near", 64'(en_a), 64'd3);
        chk("R2 two ones far", 64'(en_b), 64'd0);

        // R3 / R6 table of chained enable patterns
        last_a = '0;
        last_b = '0;
        for (int i = 0; i < 4; i++) begin
            send_chain({1'b0, VEC[i][95:48]}, {1'b0, VEC[i][47:0]});
            latch_pulse();
            chk("R3 R6 far enables", 64'(en_b), 64'(VEC[i][95:48]));
            chk("R3 R6 near enables", 64'(en_a), 64'(VEC[i][47:0]));
            last_b = VEC[i][95:48];
            last_a = VEC[i][47:0];
        end

        // R4 status readback with select 0
        read_chain(got);
        chk("R4 far status sel0", 64'(got[97:49]), 64'({1'b0, SW_B[0 +: 48]}));
        chk("R4 near status sel0", 64'(got[48:0]), 64'({1'b0, SW_A[0 +: 48]}));

        // R5 control latch: near sel=2, far sel=1
        send_chain({1'b1, 18'h2_0001, 9'o713, 21'h1A_2B3C},
                   {1'b1, 18'h3_FFF2, 9'o246, 21'h05_4321});
        latch_pulse();
        chk("R5 near bright", 64'(br_a), 64'(21'h05_4321));
        chk("R5 near maxcur", 64'(mc_a), 64'(9'o246));
        chk("R5 near func", 64'(fc_a), 64'(18'h3_FFF2));
        chk("R5 far bright", 64'(br_b), 64'(21'h1A_2B3C));
        chk("R5 far maxcur", 64'(mc_b), 64'(9'o713));
        chk("R5 far func", 64'(fc_b), 64'(18'h2_0001));
        chk("R5 near enables kept", 64'(en_a), 64'(last_a));
        chk("R5 far enables kept", 64'(en_b), 64'(last_b));

        // R4 status select follows the control field
        send_chain({1'b0, 48'h0F0F_0F0F_0F0F}, {1'b0, 48'hF0F0_F0F0_F0F0});
        latch_pulse();
        chk("R3 far after ctl", 64'(en_b), 64'h0F0F_0F0F_0F0F);
        read_chain(got);
        chk("R4 far status sel1", 64'(got[97:49]), 64'({1'b0, SW_B[48 +: 48]}));
        chk("R4 near status sel2", 64'(got[48:0]), 64'({1'b0, SW_A[96 +: 48]}));

        // R7 blanking
        blank_in = 1'b1;
        waitn(6);
        chk("R7 blank near", 64'(en_a), 64'd0);
        chk("R7 blank far", 64'(en_b), 64'd0);
        blank_in = 1'b0;
        waitn(6);
        chk("R7 unblank near", 64'(en_a), 64'hF0F0_F0F0_F0F0);
        chk("R7 unblank far", 64'(en_b), 64'h0F0F_0F0F_0F0F);

        // R1 reset clears loaded latches
        rst_n = 1'b0;
        waitn(2);
        rst_n = 1'b1;
        waitn(2);
        chk("R1 reset enables", 64'(en_a), 64'd0);
        chk("R1 reset bright", 64'(br_b), 64'd0);
        chk("R1 reset func", 64'(fc_a), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule